// File: doc/BRIEF.md
# Full-Bridge Switch Sequencer with Dead Time

This block turns a requested bridge state and a current direction into the four switch enables of one full bridge: two high-side switches and two low-side switches, one pair per leg. A winding driver asks for one of four bridge states: charge, slow decay, fast decay or off. The sequencer applies the matching switch pattern for the requested polarity.

Whenever the request changes, the sequencer first turns every switch off for a fixed number of clock cycles. Only then does it apply the new pattern. A request that arrives while that interval is running restarts the interval and replaces the pending target.

A low enable or an active thermal fault cuts all four switches at once. A thermal fault also raises a protect flag. When the enable returns or the fault clears, the same dead interval runs before any switch turns on again.

Top module: `hbridge_sequencer`

## Requirements
- R1: During and right after reset, all four switch outputs are low and `protect` is low.
- R2: With `polarity` = 0, mode code 1 (charge) drives upper_left and lower_right. Mode code 2 (slow decay) drives lower_left and lower_right. Mode code 3 (fast decay) drives upper_right and lower_left.
- R3: With `polarity` = 1, mode code 1 drives upper_right and lower_left. Mode code 2 drives lower_left and lower_right. Mode code 3 drives upper_left and lower_right.
- R4: When the pair {mode, polarity} differs from the one sampled at the previous clock edge, all switches are off for DEAD_CYCLES cycles, starting at the edge that samples the new pair. The new pattern appears after the following edge.
- R5: A request change during the dead interval restarts the full interval. The pattern that follows is that of the latest request.
- R6: An unchanged request keeps its pattern on, with no gap.
- R7: While `enable` is low, all switches are off in the same cycle, with no clock edge needed. After `enable` rises, the switches stay off for DEAD_CYCLES edges before the current request's pattern appears.
- R8: While `fault` is high, all switches are off and `protect` is high in the same cycle. After `fault` clears, `protect` drops at once and the switches stay off for DEAD_CYCLES edges.
- R9: The upper and lower switch of one leg (upper_left with lower_left, upper_right with lower_right) are never on together.
- R10: Mode code 0 (off) turns every switch off for either polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | High lets the bridge conduct |
| fault | input | 1 | Thermal fault, high forces all switches off |
| mode | input | 2 | Requested state: 0 off, 1 charge, 2 slow decay, 3 fast decay |
| polarity | input | 1 | Current direction: 0 positive, 1 negative |
| upper_left | output | 1 | High-side switch, left leg |
| upper_right | output | 1 | High-side switch, right leg |
| lower_left | output | 1 | Low-side switch, left leg |
| lower_right | output | 1 | Low-side switch, right leg |
| protect | output | 1 | High while the thermal fault is active |

## Verification
The assertions assume that `mode`, `polarity`, `enable` and `fault` are synchronous to `clk` and settle well before each rising edge. A request is therefore taken to change only at a clock edge, and the one-cycle checks of the all-off response rely on that. The bench honours this by changing every input on the falling edge and sampling outputs either on the falling edge or a small delay after it. The immediate cut-off of R7 and R8 is observed combinationally between edges.

// File: rtl/hbridge_sequencer.sv
module hbridge_sequencer #(
  parameter int DEAD_CYCLES = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       fault,
  input  logic [1:0] mode,
  input  logic       polarity,
  output logic       upper_left,
  output logic       upper_right,
  output logic       lower_left,
  output logic       lower_right,
  output logic       protect
);

  localparam int CW = $clog2(DEAD_CYCLES + 1);
  localparam logic [CW-1:0] DEAD_LOAD = CW'(DEAD_CYCLES);

  localparam logic [1:0] M_OFF    = 2'd0;
  localparam logic [1:0] M_CHARGE = 2'd1;
  localparam logic [1:0] M_SLOW   = 2'd2;
  localparam logic [1:0] M_FAST   = 2'd3;

  logic [2:0]    req, tgt;
  logic [CW-1:0] cnt;
  logic [3:0]    pat, sw;
  logic          blocked;

  assign req     = {mode, polarity};
  assign blocked = !enable || fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt <= {M_OFF, 1'b0};
      cnt <= '0;
    end else begin
      tgt <= req;
      if (req != tgt || blocked)
        cnt <= DEAD_LOAD;
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  // sw = {upper_left, upper_right, lower_left, lower_right}
  always_comb begin
    case (tgt[2:1])
      M_CHARGE: pat = tgt[0] ? 4'b0110 : 4'b1001;
      M_SLOW:   pat = 4'b0011;
      M_FAST:   pat = tgt[0] ? 4'b1001 : 4'b0110;
      default:  pat = 4'b0000;
    endcase
  end

  assign sw = (cnt == '0 && !blocked) ? pat : 4'b0000;

  assign upper_left  = sw[3];
  assign upper_right = sw[2];
  assign lower_left  = sw[1];
  assign lower_right = sw[0];
  assign protect     = fault;

  assert_no_shoot_through_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(upper_left && lower_left) && !(upper_right && lower_right));

  assert_two_switches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sw) == 0 || $countones(sw) == 2);

  assert_change_goes_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req != tgt) |=> (sw == 4'b0000));

  assert_enable_return_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> (sw == 4'b0000));

  assert_fault_clear_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault) |-> (sw == 4'b0000 && !protect));

endmodule

// File: tb/hbridge_sequencer_test.sv
module hbridge_sequencer_test;
  localparam int D = 5;

  logic clk = 1'b0;
  logic rst_n, enable, fault, polarity;
  logic [1:0] mode;
  logic ul, ur, ll, lr, prot;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hbridge_sequencer #(.DEAD_CYCLES(D)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fault(fault),
    .mode(mode), .polarity(polarity),
    .upper_left(ul), .upper_right(ur), .lower_left(ll), .lower_right(lr),
    .protect(prot));

  // {mode, polarity, expected {ul,ur,ll,lr}}
  localparam logic [6:0] VEC [8] = '{
    {2'd1, 1'b0, 4'b1001},
    {2'd2, 1'b0, 4'b0011},
    {2'd3, 1'b0, 4'b0110},
    {2'd1, 1'b1, 4'b0110},
    {2'd2, 1'b1, 4'b0011},
    {2'd3, 1'b1, 4'b1001},
    {2'd0, 1'b0, 4'b0000},
    {2'd1, 1'b0, 4'b1001}
  };

  task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {ul, ur, ll, lr, prot};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enable = 1'b1; fault = 1'b0; mode = 2'd0; polarity = 1'b0;
    step(3);
    check("R1 in reset", outs(), 5'b00000);
    rst_n = 1'b1;
    step(2);
    check("R1 after reset", outs(), 5'b00000);

    for (int i = 0; i < 8; i++) begin
      mode = VEC[i][6:5];
      polarity = VEC[i][4];
      step(D);
      check("R4 dead interval", outs(), 5'b00000);
      step(1);
      if (VEC[i][6:5] == 2'd0)      check("R10 off mode", outs(), {VEC[i][3:0], 1'b0});
      else if (VEC[i][4] == 1'b0)   check("R2 positive pattern", outs(), {VEC[i][3:0], 1'b0});
      else                          check("R3 negative pattern", outs(), {VEC[i][3:0], 1'b0});
    end

    mode = 2'd3; polarity = 1'b0;
    step(3);
    mode = 2'd1; polarity = 1'b1;
    step(D);
    check("R5 restarted interval", outs(), 5'b00000);
    step(1);
    check("R5 latest target", outs(), 5'b01100);

    for (int k = 0; k < 3; k++) begin
      step(1);
      check("R6 held pattern", outs(), 5'b01100);
    end

    enable = 1'b0;
    #1;
    check("R7 immediate off", outs(), 5'b00000);
    step(2);
    enable = 1'b1;
    step(D - 1);
    check("R7 dark after enable", outs(), 5'b00000);
    step(1);
    check("R7 pattern back", outs(), 5'b01100);

    enable = 1'b0;
    mode = 2'd1; polarity = 1'b0;
    step(3);
    enable = 1'b1;
    step(D - 1);
    check("R7 dark with new request", outs(), 5'b00000);
    step(1);
    check("R7 new request pattern", outs(), 5'b10010);

    fault = 1'b1;
    #1;
    check("R8 fault cut and protect", outs(), 5'b00001);
    step(2);
    check("R8 fault held", outs(), 5'b00001);
    fault = 1'b0;
    #1;
    check("R8 protect drops", outs(), 5'b00000);
    step(D - 1);
    check("R8 dark after fault", outs(), 5'b00000);
    step(1);
    check("R8 pattern back", outs(), 5'b10010);

    mode = 2'd0; polarity = 1'b1;
    step(D + 1);
    check("R10 off negative", outs(), 5'b00000);

    mode = 2'd2;
    step(D + 1);
    check("R3 slow negative", outs(), 5'b00110);
    rst_n = 1'b0;
    step(1);
    check("R1 mid-run reset", outs(), 5'b00000);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule